// File: doc/BRIEF.md
# Planar VGA Write-Path Unit

This unit forms the data that a four-plane, VGA-compatible graphics controller writes to its frame buffer. A host data byte goes in and a 32-bit word comes out, one byte per plane. On the way, the byte is rotated right. It is then expanded into four plane bytes according to the selected write mode. A two-operand logic stage merges it with the 32-bit display latch. Last, an 8-bit selector chooses, for each bit column, between the merged value and the latch.

The block is used beside an address generator and a read path that loads the latch; neither is part of it. The control registers are plain inputs, held steady while writes are issued: rotate amount, logic function, write mode, set/reset value, set/reset enable, column mask and plane enable. Each accepted host write produces one registered output word, its plane byte-enables and a strobe on the following clock.

Top module: `vga_wr_path`

## Requirements
- R1: `out_strobe` is high in the cycle after a cycle with `wr_valid` high, and low after a cycle with `wr_valid` low.
- R2: `out_be` equals the `plane_en` value captured with the accepted write; bit b enables plane b, which is `out_data[8b+7:8b]`.
- R3: The host byte is rotated right by `rot_count` (0 to 7) places: rotated bit n is host bit (n+rot_count) mod 8.
- R4: With `wr_mode` 0, plane byte b is eight copies of `set_reset[b]` when `enable_sr[b]` is 1, and is the rotated host byte otherwise.
- R5: With `wr_mode` 1, `out_data` equals the captured latch word; the host byte, logic function and column mask have no effect.
- R6: With `wr_mode` 2, plane byte b is eight copies of the unrotated host bit b, for b from 0 to 3.
- R7: With `wr_mode` 3, plane byte b is eight copies of `set_reset[b]`, and the column mask in use is the rotated host byte ANDed with `bit_mask`.
- R8: `logic_fn` selects how the expanded word meets the latch: 0 copies the expanded word, 1 ANDs, 2 ORs and 3 XORs.
- R9: Bit n of the column mask selects, for bit n of every plane byte, the logic result when 1 and the latch bit when 0; in modes 0 and 2 the column mask is `bit_mask`.
- R10: After reset, `out_strobe`, `out_data` and `out_be` are all zero.
- R11: `out_data` and `out_be` hold their values through cycles with no accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host write accepted this cycle |
| host_byte | input | 8 | Host data byte |
| latch_word | input | 32 | Display latch, plane b in bits 8b+7:8b |
| rot_count | input | 3 | Right-rotate amount |
| logic_fn | input | 2 | Logic function code |
| wr_mode | input | 2 | Write mode 0 to 3 |
| set_reset | input | 4 | Per-plane fill bit |
| enable_sr | input | 4 | Per-plane fill enable for mode 0 |
| bit_mask | input | 8 | Column mask register |
| plane_en | input | 4 | Plane write enables |
| out_strobe | output | 1 | Output word valid |
| out_data | output | 32 | Word to write |
| out_be | output | 4 | Plane byte-enables |

## Verification
Mode 0 is tried with all set/reset enables off and with rotation and a full mask. This isolates the rotator from the substitution. Mixed enable patterns then show that each plane chooses its own source. Distinct host bytes in mode 2 with a nonzero rotate amount show that nibble replication reads the unrotated byte. Mode 3 with a host byte whose rotation differs from itself shows that the column mask is built from the rotated byte. Latch-heavy patterns run under every logic code and under masks of zero and partial ones, so that latch pass-through stays apart from the AND/OR/XOR results. A long random mix across all modes then compares each output with an independent per-bit model.

// File: rtl/vga_wr_pkg.sv
package vga_wr_pkg;
  localparam int PLANES = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = PLANES * BYTE_W;
  localparam int ROT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    LF_COPY = 2'd0,
    LF_AND  = 2'd1,
    LF_OR   = 2'd2,
    LF_XOR  = 2'd3
  } logic_fn_e;

  typedef enum logic [1:0] {
    WM_SUBST  = 2'd0,
    WM_LATCH  = 2'd1,
    WM_NIBBLE = 2'd2,
    WM_FILL   = 2'd3
  } wr_mode_e;

  // right rotate: result bit i takes source bit (i+k) mod width
  function automatic logic [BYTE_W-1:0] rot_right(input logic [BYTE_W-1:0] v,
                                                  input logic [ROT_W-1:0] k);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) begin
      r[i] = v[(i + int'(k)) % BYTE_W];
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] combine(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] l,
                                                input logic_fn_e fn);
    logic [WORD_W-1:0] r;
    case (fn)
      LF_AND:  r = a & l;
      LF_OR:   r = a | l;
      LF_XOR:  r = a ^ l;
      default: r = a;
    endcase
    return r;
  endfunction

  // per-column choice: mask bit 1 keeps the logic result, 0 keeps the latch
  function automatic logic [BYTE_W-1:0] column_pick(input logic [BYTE_W-1:0] res,
                                                    input logic [BYTE_W-1:0] lat,
                                                    input logic [BYTE_W-1:0] m);
    return (res & m) | (lat & ~m);
  endfunction
endpackage

// File: rtl/wrp_rotator.sv
module wrp_rotator
  import vga_wr_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  input  logic [ROT_W-1:0]  amount,
  output logic [BYTE_W-1:0] dout
);
  always_comb dout = rot_right(din, amount);
endmodule

// File: rtl/wrp_expander.sv
module wrp_expander
  import vga_wr_pkg::*;
(
  input  wr_mode_e          mode,
  input  logic [BYTE_W-1:0] raw_byte,
  input  logic [BYTE_W-1:0] rot_byte,
  input  logic [PLANES-1:0] set_reset,
  input  logic [PLANES-1:0] enable_sr,
  input  logic [BYTE_W-1:0] bit_mask,
  output logic [WORD_W-1:0] exp_word,
  output logic [BYTE_W-1:0] eff_mask,
  output logic              bypass
);
  genvar p;
  generate
    for (p = 0; p < PLANES; p++) begin : g_plane
      logic [BYTE_W-1:0] pb;
      always_comb begin
        case (mode)
          WM_SUBST:  pb = enable_sr[p] ? {BYTE_W{set_reset[p]}} : rot_byte;
          WM_NIBBLE: pb = {BYTE_W{raw_byte[p]}};
          WM_FILL:   pb = {BYTE_W{set_reset[p]}};
          default:   pb = '0;
        endcase
      end
      assign exp_word[p*BYTE_W +: BYTE_W] = pb;
    end
  endgenerate

  always_comb begin
    eff_mask = (mode == WM_FILL) ? (rot_byte & bit_mask) : bit_mask;
    bypass   = (mode == WM_LATCH);
  end
endmodule

// File: rtl/wrp_merge.sv
module wrp_merge
  import vga_wr_pkg::*;
(
  input  logic [WORD_W-1:0] exp_word,
  input  logic [WORD_W-1:0] latch_word,
  input  logic_fn_e         fn,
  input  logic [BYTE_W-1:0] eff_mask,
  input  logic              bypass,
  output logic [WORD_W-1:0] alu_word,
  output logic [WORD_W-1:0] result
);
  always_comb alu_word = combine(exp_word, latch_word, fn);

  genvar p;
  generate
    for (p = 0; p < PLANES; p++) begin : g_col
      logic [BYTE_W-1:0] picked;
      always_comb picked = column_pick(alu_word[p*BYTE_W +: BYTE_W],
                                       latch_word[p*BYTE_W +: BYTE_W], eff_mask);
      assign result[p*BYTE_W +: BYTE_W] =
        bypass ? latch_word[p*BYTE_W +: BYTE_W] : picked;
    end
  endgenerate
endmodule

// File: rtl/vga_wr_path.sv
module vga_wr_path
  import vga_wr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [7:0]  host_byte,
  input  logic [31:0] latch_word,
  input  logic [2:0]  rot_count,
  input  logic [1:0]  logic_fn,
  input  logic [1:0]  wr_mode,
  input  logic [3:0]  set_reset,
  input  logic [3:0]  enable_sr,
  input  logic [7:0]  bit_mask,
  input  logic [3:0]  plane_en,
  output logic        out_strobe,
  output logic [31:0] out_data,
  output logic [3:0]  out_be
);
  wr_mode_e          mode_q;
  logic_fn_e         fn_q;
  logic [BYTE_W-1:0] rot_byte;
  logic [WORD_W-1:0] exp_word;
  logic [WORD_W-1:0] alu_word;
  logic [WORD_W-1:0] next_word;
  logic [BYTE_W-1:0] eff_mask;
  logic              bypass;

  assign mode_q = wr_mode_e'(wr_mode);
  assign fn_q   = logic_fn_e'(logic_fn);

  wrp_rotator u_rot (
    .din    (host_byte),
    .amount (rot_count),
    .dout   (rot_byte)
  );

  wrp_expander u_exp (
    .mode      (mode_q),
    .raw_byte  (host_byte),
    .rot_byte  (rot_byte),
    .set_reset (set_reset),
    .enable_sr (enable_sr),
    .bit_mask  (bit_mask),
    .exp_word  (exp_word),
    .eff_mask  (eff_mask),
    .bypass    (bypass)
  );

  wrp_merge u_mrg (
    .exp_word   (exp_word),
    .latch_word (latch_word),
    .fn         (fn_q),
    .eff_mask   (eff_mask),
    .bypass     (bypass),
    .alu_word   (alu_word),
    .result     (next_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_strobe <= 1'b0;
      out_data   <= '0;
      out_be     <= '0;
    end else begin
      out_strobe <= wr_valid;
      if (wr_valid) begin
        out_data <= next_word;
        out_be   <= plane_en;
      end
    end
  end
endmodule

// File: rtl/vga_wr_chk.sv
module vga_wr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [7:0]  host_byte,
  input logic [7:0]  rot_byte,
  input logic [31:0] latch_word,
  input logic [1:0]  wr_mode,
  input logic [7:0]  bit_mask,
  input logic [3:0]  plane_en,
  input logic        out_strobe,
  input logic [31:0] out_data,
  input logic [3:0]  out_be
);
  p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> out_strobe);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !out_strobe);
  p_be_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> out_be == $past(plane_en));
  p_rot_keeps_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rot_byte) == $countones(host_byte));
  p_latch_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_mode == 2'd1) |=> out_data == $past(latch_word));
  p_zero_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && bit_mask == 8'h00) |=> out_data == $past(latch_word));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ($stable(out_data) && $stable(out_be)));
endmodule

bind vga_wr_path vga_wr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .host_byte  (host_byte),
  .rot_byte   (rot_byte),
  .latch_word (latch_word),
  .wr_mode    (wr_mode),
  .bit_mask   (bit_mask),
  .plane_en   (plane_en),
  .out_strobe (out_strobe),
  .out_data   (out_data),
  .out_be     (out_be)
);

// File: tb/sim_vga_wr_path.sv
module sim_vga_wr_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  host_byte = '0;
  logic [31:0] latch_word = '0;
  logic [2:0]  rot_count = '0;
  logic [1:0]  logic_fn = '0;
  logic [1:0]  wr_mode = '0;
  logic [3:0]  set_reset = '0;
  logic [3:0]  enable_sr = '0;
  logic [7:0]  bit_mask = '0;
  logic [3:0]  plane_en = '0;
  logic        out_strobe;
  logic [31:0] out_data;
  logic [3:0]  out_be;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] data;
    logic [3:0]  be;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [31:0] last_data = '0;
  logic [3:0]  last_be = '0;

  always #2.5 clk = ~clk;

  vga_wr_path u0 (.*);

  // independent per-bit model built from the requirement text
  function automatic logic [31:0] model(input logic [7:0] h, input logic [31:0] l,
      input logic [2:0] rc, input logic [1:0] fn, input logic [1:0] md,
      input logic [3:0] sr, input logic [3:0] esr, input logic [7:0] bm);
    logic [15:0] dbl;
    logic [7:0]  r;
    logic [31:0] o;
    dbl = {h, h} >> rc;
    r = dbl[7:0];
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        logic e, a, lb, m;
        lb = l[8*b+n];
        case (md)
          2'd0: e = esr[b] ? sr[b] : r[n];
          2'd2: e = h[b];
          default: e = sr[b];
        endcase
        case (fn)
          2'd1: a = e & lb;
          2'd2: a = e | lb;
          2'd3: a = e ^ lb;
          default: a = e;
        endcase
        m = (md == 2'd3) ? (r[n] & bm[n]) : bm[n];
        o[8*b+n] = (md == 2'd1) ? lb : (m ? a : lb);
      end
    end
    return o;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic do_write(input string tag, input logic [7:0] h, input logic [31:0] l,
      input logic [2:0] rc, input logic [1:0] fn, input logic [1:0] md,
      input logic [3:0] sr, input logic [3:0] esr, input logic [7:0] bm,
      input logic [3:0] pe);
    exp_t it;
    @(negedge clk);
    host_byte = h; latch_word = l; rot_count = rc; logic_fn = fn; wr_mode = md;
    set_reset = sr; enable_sr = esr; bit_mask = bm; plane_en = pe;
    wr_valid = 1'b1;
    it.data = model(h, l, rc, fn, md, sr, esr, bm);
    it.be = pe;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare each strobed result against the oldest expected item
  always @(negedge clk) begin
    if (rst_n && out_strobe) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R1: actual=strobe expected=none");
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(it.tag, out_data, it.data);
        check("R2 byte enables", {28'd0, out_be}, {28'd0, it.be});
        last_data = out_data;
        last_be = out_be;
      end
    end
  end

  initial begin
    idle(2);
    total++;
    if (out_strobe !== 1'b0 || out_data !== 32'd0 || out_be !== 4'd0) begin
      bad++;
      $display("FAIL R10: actual=%b/%h/%h expected=0/0/0", out_strobe, out_data, out_be);
    end
    rst_n = 1'b1;
    idle(2);
    // R3 rotation isolated: mode 0, no substitution, copy, full mask
    do_write("R3 rot0", 8'hA5, 32'h0, 3'd0, 2'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF);
    do_write("R3 rot1", 8'h01, 32'h0, 3'd1, 2'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF);
    do_write("R3 rot7", 8'h81, 32'h0, 3'd7, 2'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF);
    // R4 mixed substitution
    do_write("R4 subst", 8'h3C, 32'h0, 3'd2, 2'd0, 2'd0, 4'b0101, 4'b0011, 8'hFF, 4'hF);
    // R5 latch mode ignores host, fn and mask
    do_write("R5 latch", 8'hFF, 32'hDEADBEEF, 3'd3, 2'd3, 2'd1, 4'hF, 4'hF, 8'h00, 4'h5);
    // R6 nibble replication from unrotated byte
    do_write("R6 nibble", 8'h0A, 32'h0, 3'd3, 2'd0, 2'd2, 4'h0, 4'h0, 8'hFF, 4'hF);
    // R7 fill with rotated host AND mask
    do_write("R7 fill", 8'h0F, 32'h12345678, 3'd2, 2'd0, 2'd3, 4'b1001, 4'h0, 8'hF0, 4'hF);
    // R8 logic codes against a latch pattern
    for (int f = 0; f < 4; f++)
      do_write("R8 logic", 8'hC3, 32'hF0F00FF0, 3'd0, 2'(f), 2'd0, 4'b0110, 4'b1100, 8'hFF, 4'hF);
    // R9 partial and empty column masks
    do_write("R9 partial", 8'hFF, 32'h55AA55AA, 3'd0, 2'd0, 2'd2, 4'h0, 4'h0, 8'h3C, 4'hF);
    do_write("R9 zero", 8'hFF, 32'h89ABCDEF, 3'd0, 2'd3, 2'd0, 4'hF, 4'hF, 8'h00, 4'hF);
    // R2 byte enables pass through
    do_write("R2 planes", 8'h11, 32'h0, 3'd0, 2'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'b1010);
    idle(3);
    // R11 hold through idle cycles
    check("R11 hold data", out_data, last_data);
    check("R11 hold be", {28'd0, out_be}, {28'd0, last_be});
    total++;
    if (out_strobe !== 1'b0) begin
      bad++;
      $display("FAIL R1: actual=%b expected=0", out_strobe);
    end
    // random mix across all modes (tags per mode)
    for (int i = 0; i < 400; i++) begin
      logic [1:0] md;
      string t;
      md = 2'($urandom);
      case (md)
        2'd0: t = "R4 random";
        2'd1: t = "R5 random";
        2'd2: t = "R6 random";
        default: t = "R7 random";
      endcase
      do_write(t, 8'($urandom), $urandom, 3'($urandom), 2'($urandom), md,
               4'($urandom), 4'($urandom), 8'($urandom), 4'($urandom));
      if ((i % 7) == 0) idle(1);
    end
    idle(4);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL R1: actual=%0d pending expected=0", sb.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule